// File: doc/BRIEF.md
# Integrating Vertical Sync Detector

This block watches a composite sync stream that has already been brought into the clock domain, active low, and finds the vertical interval in it. A saturating up/down integrator charges by one step for every cycle the sync line is low and drains by a larger step for every cycle it is high. Only the wide low pulses of the vertical interval can drive it to the threshold. Horizontal sync, equalizing pulses and short noise bursts cannot.

The block produces an active-low vertical pulse, `vsync_n`. The pulse starts at the rising edge that ends a qualifying wide pulse, which is the first serration. If the interval carries no serrations, a fallback timer starts the pulse instead, a fixed number of low cycles into the wide pulse. The pulse ends at a counted rising edge of the narrow pulses that follow the interval, which is the second one by default. Because both ends sit on sync edges, the pulse width for standard video is fixed by the line structure and not by any timer.

A separate flag, `nosync`, goes high once the sync line has stayed high for a programmable number of cycles, about one and a half lines. It drops as soon as sync goes low again. Other logic can use it to speed up recovery after impulse noise. Every timing value is a parameter in clock cycles.

Top module: `vsync_detector`

## Requirements
- R1: While reset is low, and after reset with no stimulus, `vsync_n` is 1 and `nosync` is 0.
- R2: Starting from an empty integrator, a low pulse of exactly THRESH consecutive cycles qualifies as a wide pulse. A low pulse of THRESH-1 cycles does not qualify, and `vsync_n` stays high.
- R3: When a qualifying pulse ends while no vertical pulse is active, `vsync_n` goes low on the clock edge that first samples `csync_n` high.
- R4: If a pulse has qualified and `csync_n` is still low, `vsync_n` goes low on the edge that samples the DFLT_START-th consecutive low cycle. Counting starts at the first low sample, which is 1.
- R5: While the vertical pulse is active, each low pulse that ends without qualifying is counted. `vsync_n` returns high on the edge that first samples `csync_n` high after the POST_EQ_END-th such pulse, which is the second one by default.
- R6: A new qualification after the detection flag has cleared, that is a wide pulse following a non-qualifying pulse, resets that count. Ending the pulse then needs POST_EQ_END fresh non-qualifying pulses.
- R7: The integrator rises by 1 per low cycle up to INTEG_MAX and falls by DISCH_STEP per high cycle down to 0. Short low spikes qualify only when their accumulated level reaches THRESH.
- R8: `nosync` rises on the edge that samples the NOSYNC_CYC-th consecutive high cycle. It falls on the edge that next samples `csync_n` low.
- R9: For a standard interval the vertical pulse starts once and runs from the end of the first wide pulse to the end of the second narrow pulse after the interval. Later wide pulses in the same interval do not start it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csync_n | input | 1 | Composite sync, synchronous to clk, active low |
| vsync_n | output | 1 | Vertical sync pulse, active low |
| nosync | output | 1 | High when no sync low has been seen for NOSYNC_CYC cycles |

## Verification
The bench builds the block with a 32-cycle line and a 16-cycle half line. It uses THRESH 8, INTEG_MAX 12, DISCH_STEP 4, DFLT_START 20, NOSYNC_CYC 48 and POST_EQ_END 2. At these sizes a full field fits in a few hundred cycles, so every edge of the vertical pulse can be predicted exactly from the stimulus timing.

The small values bring the one-cycle boundaries into reach: pulses of THRESH-1 and THRESH cycles, high gaps of 47 and 48 cycles, and spike trains whose accumulation can be worked out by hand. The same settings cover an interval with no serrations, a wide pulse that reappears after the post-interval count has started, and trains of noise spikes.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

  // Sampled view of the sync line for one cycle
  typedef struct packed {
    logic low;   // sync is low in this cycle
    logic fall;  // first low cycle of a pulse
    logic rise;  // first high cycle after a pulse
  } sync_ev_t;

  // Add delta to val and clamp the result to the range [0, ceil_v]
  function automatic int sat_step(input int val, input int delta, input int ceil_v);
    int r;
    r = val + delta;
    if (r < 0) r = 0;
    else if (r > ceil_v) r = ceil_v;
    return r;
  endfunction

  // Signed change applied to the integrator in one cycle
  function automatic int integ_delta(input logic is_low, input int disch);
    return is_low ? 1 : -disch;
  endfunction

  // Whether an integrator level has crossed the qualification point
  function automatic logic level_qualifies(input int level, input int thresh);
    return level >= thresh;
  endfunction

endpackage

// File: rtl/vsd_edge.sv
module vsd_edge
  import vsd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     csync_n,
  output sync_ev_t ev
);

  logic prev_q;

  // The idle level of the sync line is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= csync_n;
  end

  always_comb begin
    ev.low  = ~csync_n;
    ev.fall =  prev_q & ~csync_n;
    ev.rise = ~prev_q &  csync_n;
  end

endmodule

// File: rtl/vsd_integrator.sv
module vsd_integrator
  import vsd_pkg::*;
#(
  parameter int INTEG_MAX  = 732,
  parameter int THRESH     = 366,
  parameter int DISCH_STEP = 6,
  localparam int IW = $clog2(INTEG_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sync_ev_t      ev,
  output logic [IW-1:0] integ_q,
  output logic          vflag_now,
  output logic          detect_new,
  output logic          pulse_hit_end,
  output logic          pulse_miss_end
);

  logic [IW-1:0] integ_nxt;
  logic          reach;
  logic          hit_q;
  logic          vflag_q;

  always_comb begin
    integ_nxt = IW'(sat_step(int'(integ_q), integ_delta(ev.low, DISCH_STEP), INTEG_MAX));
    reach     = ev.low & level_qualifies(int'(integ_nxt), THRESH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) integ_q <= '0;
    else        integ_q <= integ_nxt;
  end

  // hit_q records whether the current or most recent pulse qualified
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hit_q <= 1'b0;
    else if (ev.fall) hit_q <= reach;
    else if (ev.low)  hit_q <= hit_q | reach;
  end

  // The flag sets on qualification and clears when a pulse ends unqualified
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              vflag_q <= 1'b0;
    else if (reach)          vflag_q <= 1'b1;
    else if (pulse_miss_end) vflag_q <= 1'b0;
  end

  always_comb begin
    vflag_now      = vflag_q | reach;
    detect_new     = reach & ~vflag_q;
    pulse_hit_end  = ev.rise &  hit_q;
    pulse_miss_end = ev.rise & ~hit_q;
  end

endmodule

// File: rtl/vsd_vctrl.sv
module vsd_vctrl
  import vsd_pkg::*;
#(
  parameter int DFLT_START  = 1755,
  parameter int POST_EQ_END = 2,
  localparam int RW = $clog2(DFLT_START + 1),
  localparam int PW = $clog2(POST_EQ_END + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sync_ev_t      ev,
  input  logic          vflag_now,
  input  logic          detect_new,
  input  logic          pulse_hit_end,
  input  logic          pulse_miss_end,
  output logic          vact_q,
  output logic [PW-1:0] pe_q,
  output logic          start_serr,
  output logic          start_dflt,
  output logic          end_evt
);

  logic [RW-1:0] run_q;
  logic [RW-1:0] run_nxt;

  // Length of the current low run, saturating at DFLT_START
  always_comb begin
    if (!ev.low)     run_nxt = '0;
    else if (ev.fall) run_nxt = RW'(1);
    else             run_nxt = RW'(sat_step(int'(run_q), 1, DFLT_START));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_nxt;
  end

  assign start_serr = pulse_hit_end & ~vact_q;
  assign start_dflt = ev.low & vflag_now & ~vact_q & (int'(run_nxt) == DFLT_START);

  // Counter for non-qualifying pulses that end the vertical pulse
  if (POST_EQ_END > 1) begin : g_pe_count
    assign end_evt = vact_q & pulse_miss_end & (int'(pe_q) == POST_EQ_END - 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       pe_q <= '0;
      else if (detect_new)              pe_q <= '0;
      else if (end_evt)                 pe_q <= '0;
      else if (vact_q & pulse_miss_end) pe_q <= PW'(int'(pe_q) + 1);
    end
  end else begin : g_pe_single
    assign end_evt = vact_q & pulse_miss_end;
    assign pe_q    = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        vact_q <= 1'b0;
    else if (start_serr | start_dflt)  vact_q <= 1'b1;
    else if (end_evt)                  vact_q <= 1'b0;
  end

endmodule

// File: rtl/vsd_nosync.sv
module vsd_nosync
  import vsd_pkg::*;
#(
  parameter int NOSYNC_CYC = 2565,
  localparam int NW = $clog2(NOSYNC_CYC + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  sync_ev_t ev,
  output logic     nosync_q
);

  logic [NW-1:0] quiet_q;
  logic [NW-1:0] quiet_nxt;

  // Consecutive high cycles, cleared by any low sample
  always_comb begin
    if (ev.low) quiet_nxt = '0;
    else        quiet_nxt = NW'(sat_step(int'(quiet_q), 1, NOSYNC_CYC));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q  <= '0;
      nosync_q <= 1'b0;
    end else begin
      quiet_q  <= quiet_nxt;
      nosync_q <= (int'(quiet_nxt) >= NOSYNC_CYC);
    end
  end

endmodule

// File: rtl/vsync_detector.sv
module vsync_detector
  import vsd_pkg::*;
#(
  parameter int INTEG_MAX   = 732,
  parameter int THRESH      = 366,
  parameter int DISCH_STEP  = 6,
  parameter int DFLT_START  = 1755,
  parameter int NOSYNC_CYC  = 2565,
  parameter int POST_EQ_END = 2,
  localparam int IW = $clog2(INTEG_MAX + 1),
  localparam int PW = $clog2(POST_EQ_END + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_n,
  output logic vsync_n,
  output logic nosync
);

  sync_ev_t      ev;
  logic [IW-1:0] integ_lvl;
  logic          vflag_now;
  logic          detect_new;
  logic          pulse_hit_end;
  logic          pulse_miss_end;
  logic          vact;
  logic [PW-1:0] pe_cnt;
  logic          start_serr;
  logic          start_dflt;
  logic          end_evt;

  vsd_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .csync_n (csync_n),
    .ev      (ev)
  );

  vsd_integrator #(
    .INTEG_MAX  (INTEG_MAX),
    .THRESH     (THRESH),
    .DISCH_STEP (DISCH_STEP)
  ) u_integ (
    .clk            (clk),
    .rst_n          (rst_n),
    .ev             (ev),
    .integ_q        (integ_lvl),
    .vflag_now      (vflag_now),
    .detect_new     (detect_new),
    .pulse_hit_end  (pulse_hit_end),
    .pulse_miss_end (pulse_miss_end)
  );

  vsd_vctrl #(
    .DFLT_START  (DFLT_START),
    .POST_EQ_END (POST_EQ_END)
  ) u_vctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .ev             (ev),
    .vflag_now      (vflag_now),
    .detect_new     (detect_new),
    .pulse_hit_end  (pulse_hit_end),
    .pulse_miss_end (pulse_miss_end),
    .vact_q         (vact),
    .pe_q           (pe_cnt),
    .start_serr     (start_serr),
    .start_dflt     (start_dflt),
    .end_evt        (end_evt)
  );

  vsd_nosync #(
    .NOSYNC_CYC (NOSYNC_CYC)
  ) u_nosync (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .nosync_q (nosync)
  );

  assign vsync_n = ~vact;

endmodule

// File: rtl/vsd_checker.sv
module vsd_checker #(
  parameter int INTEG_MAX   = 732,
  parameter int POST_EQ_END = 2,
  localparam int IW = $clog2(INTEG_MAX + 1),
  localparam int PW = $clog2(POST_EQ_END + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          csync_n,
  input logic          vsync_n,
  input logic          nosync,
  input logic [IW-1:0] integ_lvl,
  input logic [PW-1:0] pe_cnt,
  input logic          start_serr,
  input logic          start_dflt,
  input logic          end_evt
);

  AST_INTEG_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    int'(integ_lvl) <= INTEG_MAX); // R7

  AST_NO_CHARGE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    csync_n |=> integ_lvl <= $past(integ_lvl)); // R7

  AST_NO_DRAIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !csync_n |=> integ_lvl >= $past(integ_lvl)); // R7

  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> $past(start_serr || start_dflt)); // R3

  AST_SERR_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    start_serr |-> csync_n); // R3

  AST_DFLT_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    start_dflt |-> !csync_n); // R4

  AST_END_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_n) |-> $past(end_evt)); // R5

  AST_END_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |-> (csync_n && !vsync_n)); // R5

  AST_PE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pe_cnt) < POST_EQ_END); // R6

  AST_NOSYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !csync_n |=> !nosync); // R8

  AST_NOSYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nosync) |-> $past(csync_n)); // R8

endmodule

bind vsync_detector vsd_checker #(
  .INTEG_MAX   (INTEG_MAX),
  .POST_EQ_END (POST_EQ_END)
) u_vsd_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .csync_n    (csync_n),
  .vsync_n    (vsync_n),
  .nosync     (nosync),
  .integ_lvl  (integ_lvl),
  .pe_cnt     (pe_cnt),
  .start_serr (start_serr),
  .start_dflt (start_dflt),
  .end_evt    (end_evt)
);

// File: tb/vsync_detector_bench.sv
module vsync_detector_bench;

  localparam int TH   = 8;
  localparam int IMAX = 12;
  localparam int DIS  = 4;
  localparam int DFLT = 20;
  localparam int NSC  = 48;
  localparam int PEE  = 2;
  localparam int HL   = 32;
  localparam int HALF = 16;
  localparam int HSW  = 3;
  localparam int EQW  = 2;
  localparam int BRW  = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csync_n = 1'b1;
  logic vsync_n;
  logic nosync;

  always #2 clk = ~clk;

  vsync_detector #(
    .INTEG_MAX   (IMAX),
    .THRESH      (TH),
    .DISCH_STEP  (DIS),
    .DFLT_START  (DFLT),
    .NOSYNC_CYC  (NSC),
    .POST_EQ_END (PEE)
  ) u_vsync_detector (
    .clk     (clk),
    .rst_n   (rst_n),
    .csync_n (csync_n),
    .vsync_n (vsync_n),
    .nosync  (nosync)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Output edge monitor, sampled between clock edges
  int   vs_fall_n = 0, vs_rise_n = 0, vs_fall_e = 0, vs_rise_e = 0;
  int   ns_rise_n = 0, ns_fall_n = 0, ns_rise_e = 0, ns_fall_e = 0;
  logic vs_prev = 1'b1, ns_prev = 1'b0;
  always @(negedge clk) begin
    if (vsync_n !== vs_prev) begin
      if (!vsync_n) begin vs_fall_n++; vs_fall_e = cyc; end
      else          begin vs_rise_n++; vs_rise_e = cyc; end
      vs_prev = vsync_n;
    end
    if (nosync !== ns_prev) begin
      if (nosync) begin ns_rise_n++; ns_rise_e = cyc; end
      else        begin ns_fall_n++; ns_fall_e = cyc; end
      ns_prev = nosync;
    end
  end

  int tests = 0;
  int fails = 0;
  int seg_edge = 0;
  int b_vf = 0, b_vr = 0, b_nr = 0;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic mark();
    b_vf = vs_fall_n;
    b_vr = vs_rise_n;
    b_nr = ns_rise_n;
  endtask

  // Hold the sync line at lvl for n cycles; seg_edge is the first edge sampling it
  task automatic seg(input logic lvl, input int n);
    csync_n  = lvl;
    seg_edge = cyc + 1;
    repeat (n) @(negedge clk);
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) begin seg(1'b0, HSW); seg(1'b1, HL - HSW); end
  endtask

  task automatic eqs(input int n);
    for (int i = 0; i < n; i++) begin seg(1'b0, EQW); seg(1'b1, HALF - EQW); end
  endtask

  task automatic broads(input int n);
    for (int i = 0; i < n; i++) begin seg(1'b0, BRW); seg(1'b1, HALF - BRW); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int exp_f, exp_r, s, kx, v;
    repeat (4) @(negedge clk);
    chk("R1 vsync_n in reset", int'(vsync_n), 1);
    chk("R1 nosync in reset", int'(nosync), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 vsync_n after reset", int'(vsync_n), 1);
    chk("R1 nosync after reset", int'(nosync), 0);

    // Standard interval
    mark();
    lines(4); eqs(6);
    seg(1'b0, BRW); seg(1'b1, HALF - BRW); exp_f = seg_edge;
    broads(5); eqs(1);
    seg(1'b0, EQW); seg(1'b1, HALF - EQW); exp_r = seg_edge;
    eqs(4); lines(4);
    chk("R9 single start", vs_fall_n - b_vf, 1);
    chk("R3 start at first serration", vs_fall_e, exp_f);
    chk("R5 end at second post pulse", vs_rise_e, exp_r);
    chk("R9 width", vs_rise_e - vs_fall_e, 6 * HALF + HALF + EQW - BRW);
    chk("R8 no flag with regular sync", ns_rise_n - b_nr, 0);

    // Threshold boundary
    mark();
    lines(2);
    seg(1'b0, TH - 1); seg(1'b1, HL - TH + 1);
    lines(2);
    chk("R2 short pulse ignored", vs_fall_n - b_vf, 0);
    seg(1'b0, TH); seg(1'b1, HL - TH); exp_f = seg_edge;
    seg(1'b0, HSW); seg(1'b1, HL - HSW);
    seg(1'b0, HSW); seg(1'b1, HL - HSW); exp_r = seg_edge;
    lines(2);
    chk("R2 pulse at threshold qualifies", vs_fall_n - b_vf, 1);
    chk("R3 start edge", vs_fall_e, exp_f);
    chk("R5 end edge after two misses", vs_rise_e, exp_r);

    // No serrations: fallback start
    mark();
    lines(2);
    seg(1'b0, 3 * HL); s = seg_edge;
    seg(1'b1, HALF - EQW);
    eqs(1);
    seg(1'b0, EQW); seg(1'b1, HALF - EQW); exp_r = seg_edge;
    eqs(4); lines(2);
    chk("R4 single start", vs_fall_n - b_vf, 1);
    chk("R4 fallback start edge", vs_fall_e, s + DFLT - 1);
    chk("R5 end after fallback", vs_rise_e, exp_r);

    // Count reset by a new qualification
    mark();
    lines(2);
    seg(1'b0, BRW); seg(1'b1, HALF - BRW); exp_f = seg_edge;
    broads(1); eqs(1); broads(1); eqs(1);
    seg(1'b0, EQW); seg(1'b1, HALF - EQW); exp_r = seg_edge;
    eqs(3); lines(2);
    chk("R6 single start", vs_fall_n - b_vf, 1);
    chk("R6 start edge", vs_fall_e, exp_f);
    chk("R6 end after count restart", vs_rise_e, exp_r);

    // Noise spikes
    mark();
    lines(2);
    for (int k = 0; k < 10; k++) begin seg(1'b0, TH - 1); seg(1'b1, 2); end
    lines(2);
    chk("R7 drained spikes ignored", vs_fall_n - b_vf, 0);
    v = 0; kx = 0;
    for (int k = 1; k <= 6; k++) begin
      if (kx == 0 && v + 5 >= TH) kx = k;
      v = (v + 5 > IMAX) ? IMAX : v + 5;
      v = (v - DIS < 0) ? 0 : v - DIS;
    end
    exp_f = 0;
    for (int k = 1; k <= 6; k++) begin
      seg(1'b0, 5); seg(1'b1, 1);
      if (k == kx) exp_f = seg_edge;
    end
    lines(4);
    chk("R7 accumulated spikes qualify", vs_fall_n - b_vf, 1);
    chk("R7 accumulated start edge", vs_fall_e, exp_f);

    // No-sync flag
    mark();
    lines(1);
    seg(1'b0, HSW); seg(1'b1, NSC - 1);
    seg(1'b0, HSW);
    chk("R8 gap of NOSYNC_CYC-1 keeps flag low", ns_rise_n - b_nr, 0);
    seg(1'b1, NSC + 10); s = seg_edge;
    chk("R8 flag rise edge", ns_rise_e, s + NSC - 1);
    chk("R8 flag high while quiet", int'(nosync), 1);
    seg(1'b0, HSW); exp_f = seg_edge;
    seg(1'b1, HL - HSW);
    chk("R8 flag clear edge", ns_fall_e, exp_f);
    lines(2);
    chk("R8 vsync untouched", vs_fall_n - b_vf, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule